// File: doc/BRIEF.md
# Windowed Video Statistics Unit

This block watches an RGB pixel stream together with positive-polarity horizontal and vertical sync. It gathers one statistic per measurement over a rectangular region of the frame. Software sets up the algorithm, the colour channel, a threshold, two mode bits and the region corners, then pulses a start request. The block waits for the next vertical sync rising edge, gathers data for exactly one frame, and at the following vertical sync rising edge writes two result words and drops its busy flag. Busy falling is the signal that the results are valid.

Pixel coordinates come from counters in the block. The column restarts at the horizontal sync rising edge and the row restarts at the vertical sync rising edge. A corner pair of (0,0) and (4095,4095) therefore covers the whole span from one sync to the next. Every accumulating statistic saturates at full scale and never wraps.

Top module: `vstat_top`

## Requirements
- R1: After reset, `busy` is 0 and both result words are 0.
- R2: A start request is taken only while `busy` is 0. Taking it sets `busy` and captures every configuration input. Configuration changes and start requests made while `busy` is 1 have no effect on the measurement in progress.
- R3: A measurement covers the cycles from the first vsync rising edge after `busy` rises up to, but not including, the next vsync rising edge. On that closing edge `busy` clears and both result words are loaded, visible one cycle later. At no other time do the result words change.
- R4: The column is 0 on the cycle hsync rises, then grows by one per clock and saturates at 4095. The row is 0 on the cycle vsync rises, grows by one on each other hsync rise, and saturates at 4095. A pixel counts only when `pix_vld` is 1 and x0 <= column <= x1 and y0 <= row <= y1.
- R5: Channel code 0 selects red, 1 selects green, 2 selects blue and 3 selects all three. In all-channel mode the per-channel contributions are combined.
- R6: Algorithm 0 (edge): for every counted pixel that has an earlier counted pixel on the same line, each selected channel adds max(|value - previous| - threshold, 0). The sum goes to `res_main` and `res_aux` is 0.
- R7: Algorithm 1 (sum) adds the selected channel values of every counted pixel into `res_main` and saturates at all ones. `res_aux` is 0.
- R8: Algorithm 2 gives the smallest selected sample in `res_main` and the largest in `res_aux`. With no counted pixel, these are 2^PIX_W-1 and 0.
- R9: Algorithm 3 counts the selected samples above the threshold. When `cnt_below` is 1 it counts the samples below the threshold instead. The count goes to `res_main` and `res_aux` is 0.
- R10: A counted pixel passes if any selected channel passes the test. The test is value > threshold, or, when `pos_diff` is 1, |value - previous counted pixel on the line| > threshold. Algorithm 4 gives the smallest passing column in `res_main` and the largest passing column plus one in `res_aux`. With no passing pixel these are 4095 and 0.
- R11: Algorithm 5 uses the same test as R10 and reports the smallest passing row and the largest passing row plus one.
- R12: Result bits above a field's width read as 0. Algorithms 6 and 7 give 0 in both words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_r | input | PIX_W | Red sample |
| pix_g | input | PIX_W | Green sample |
| pix_b | input | PIX_W | Blue sample |
| pix_vld | input | 1 | Sample qualifier |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| req_start | input | 1 | Start request |
| sel_alg | input | 3 | Algorithm code |
| sel_chan | input | 2 | Channel code |
| thr_level | input | PIX_W | Shared threshold |
| cnt_below | input | 1 | Count samples below the threshold |
| pos_diff | input | 1 | Position test uses the neighbour difference |
| win_x0 | input | COORD_W | Left column |
| win_y0 | input | COORD_W | Top row |
| win_x1 | input | COORD_W | Right column |
| win_y1 | input | COORD_W | Bottom row |
| busy | output | 1 | Start bit, clears when results are ready |
| res_main | output | ACC_W | First result word |
| res_aux | output | ACC_W | Second result word |

## Verification
The bench targets several corner cases:
- A region that holds no pixel. A design that starts min/max or position from zero instead of the empty values would report a false minimum or start.
- A frame of full-scale samples with a narrow accumulator. A wrapping adder would give a small sum instead of all ones.
- Configuration and start requests toggled during a measurement. A design that reads live inputs would mix settings within a frame.
- The first pixel of each line in edge and difference modes. A design that carries the previous pixel across lines would add false edges at the left boundary.

// File: rtl/vstat_pkg.sv
package vstat_pkg;
  typedef enum logic [2:0] {
    ALG_EDGE   = 3'd0,
    ALG_SUM    = 3'd1,
    ALG_MINMAX = 3'd2,
    ALG_COUNT  = 3'd3,
    ALG_HPOS   = 3'd4,
    ALG_VPOS   = 3'd5,
    ALG_RSV6   = 3'd6,
    ALG_RSV7   = 3'd7
  } alg_e;

  typedef enum logic [1:0] {
    CH_RED   = 2'd0,
    CH_GREEN = 2'd1,
    CH_BLUE  = 2'd2,
    CH_ALL   = 2'd3
  } chan_e;

  localparam int NUM_CH = 3;
endpackage

// File: rtl/vstat_coord.sv
module vstat_coord #(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hsync,
  input  logic               vsync,
  output logic               hs_rise,
  output logic               vs_rise,
  output logic [COORD_W-1:0] cur_x,
  output logic [COORD_W-1:0] cur_y
);
  localparam logic [COORD_W-1:0] CMAX = '1;

  logic               hs_d, vs_d;
  logic [COORD_W-1:0] x_q, y_q;

  assign hs_rise = hsync & ~hs_d;
  assign vs_rise = vsync & ~vs_d;

  // position of the sample present on this cycle
  always_comb begin
    if (hs_rise)         cur_x = '0;
    else if (x_q == CMAX) cur_x = CMAX;
    else                 cur_x = x_q + 1'b1;

    if (vs_rise)                     cur_y = '0;
    else if (hs_rise && y_q != CMAX) cur_y = y_q + 1'b1;
    else                             cur_y = y_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_d <= 1'b0;
      vs_d <= 1'b0;
      x_q  <= CMAX;
      y_q  <= CMAX;
    end else begin
      hs_d <= hsync;
      vs_d <= vsync;
      x_q  <= cur_x;
      y_q  <= cur_y;
    end
  end

  AST_X_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |=> (x_q == '0)); // R4
  AST_Y_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |=> (y_q == '0)); // R4
endmodule

// File: rtl/vstat_ctrl.sv
module vstat_ctrl
  import vstat_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_start,
  input  logic               vs_rise,
  input  logic [2:0]         in_alg,
  input  logic [1:0]         in_chan,
  input  logic [PIX_W-1:0]   in_thr,
  input  logic               in_below,
  input  logic               in_diff,
  input  logic [COORD_W-1:0] in_x0,
  input  logic [COORD_W-1:0] in_y0,
  input  logic [COORD_W-1:0] in_x1,
  input  logic [COORD_W-1:0] in_y1,
  output logic               busy,
  output logic               running,
  output logic               frame_start,
  output logic               frame_end,
  output alg_e               alg_q,
  output logic [1:0]         chan_q,
  output logic [PIX_W-1:0]   thr_q,
  output logic               below_q,
  output logic               diff_q,
  output logic [COORD_W-1:0] x0_q,
  output logic [COORD_W-1:0] y0_q,
  output logic [COORD_W-1:0] x1_q,
  output logic [COORD_W-1:0] y1_q
);
  logic take_req;

  assign take_req    = req_start & ~busy;
  assign frame_start = busy & ~running & vs_rise;
  assign frame_end   = running & vs_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      running <= 1'b0;
      alg_q   <= ALG_EDGE;
      chan_q  <= '0;
      thr_q   <= '0;
      below_q <= 1'b0;
      diff_q  <= 1'b0;
      x0_q    <= '0;
      y0_q    <= '0;
      x1_q    <= '0;
      y1_q    <= '0;
    end else if (take_req) begin
      busy    <= 1'b1;
      alg_q   <= alg_e'(in_alg);
      chan_q  <= in_chan;
      thr_q   <= in_thr;
      below_q <= in_below;
      diff_q  <= in_diff;
      x0_q    <= in_x0;
      y0_q    <= in_y0;
      x1_q    <= in_x1;
      y1_q    <= in_y1;
    end else if (frame_end) begin
      busy    <= 1'b0;
      running <= 1'b0;
    end else if (frame_start) begin
      running <= 1'b1;
    end
  end

  AST_START_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !busy); // R3
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(alg_q) && $stable(chan_q) && $stable(thr_q) && $stable(below_q)
              && $stable(diff_q) && $stable(x0_q) && $stable(y0_q)
              && $stable(x1_q) && $stable(y1_q))); // R2
endmodule

// File: rtl/vstat_sample.sv
module vstat_sample
  import vstat_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hs_rise,
  input  logic [PIX_W-1:0]   pix_r,
  input  logic [PIX_W-1:0]   pix_g,
  input  logic [PIX_W-1:0]   pix_b,
  input  logic               pix_vld,
  input  logic [COORD_W-1:0] cur_x,
  input  logic [COORD_W-1:0] cur_y,
  input  logic [COORD_W-1:0] x0,
  input  logic [COORD_W-1:0] y0,
  input  logic [COORD_W-1:0] x1,
  input  logic [COORD_W-1:0] y1,
  input  logic [1:0]         chan,
  input  logic [PIX_W-1:0]   thr,
  input  logic               below,
  input  logic               diff_mode,
  output logic               in_win,
  output logic [PIX_W+1:0]   edge_term,
  output logic [PIX_W+1:0]   sum_term,
  output logic [1:0]         cnt_term,
  output logic [PIX_W-1:0]   smp_min,
  output logic [PIX_W-1:0]   smp_max,
  output logic               pos_pass
);
  localparam int TW = PIX_W + 2;

  function automatic logic [PIX_W-1:0] abs_gap(input logic [PIX_W-1:0] a,
                                               input logic [PIX_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic logic [PIX_W-1:0] shave(input logic [PIX_W-1:0] d,
                                             input logic [PIX_W-1:0] t);
    return (d > t) ? (d - t) : '0;
  endfunction

  logic [PIX_W-1:0] cur_v [NUM_CH];
  logic [PIX_W-1:0] prv_v [NUM_CH];
  logic [PIX_W-1:0] e_c   [NUM_CH];
  logic [PIX_W-1:0] s_c   [NUM_CH];
  logic [PIX_W-1:0] mn_c  [NUM_CH];
  logic [PIX_W-1:0] mx_c  [NUM_CH];
  logic [NUM_CH-1:0] hit_c, pass_c, use_c;
  logic prev_ok, prev_eff;

  assign cur_v[0] = pix_r;
  assign cur_v[1] = pix_g;
  assign cur_v[2] = pix_b;

  assign in_win = pix_vld && (cur_x >= x0) && (cur_x <= x1)
                          && (cur_y >= y0) && (cur_y <= y1);

  // the first counted pixel on a line has no neighbour
  assign prev_eff = prev_ok & ~hs_rise;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [PIX_W-1:0] gap;
    assign use_c[c]  = (chan == CH_ALL) || (chan == 2'(c));
    assign gap       = abs_gap(cur_v[c], prv_v[c]);
    assign e_c[c]    = (use_c[c] && prev_eff) ? shave(gap, thr) : '0;
    assign s_c[c]    = use_c[c] ? cur_v[c] : '0;
    assign mn_c[c]   = use_c[c] ? cur_v[c] : '1;
    assign mx_c[c]   = use_c[c] ? cur_v[c] : '0;
    assign hit_c[c]  = use_c[c] && (below ? (cur_v[c] < thr) : (cur_v[c] > thr));
    assign pass_c[c] = use_c[c] && (diff_mode ? (prev_eff && (gap > thr))
                                              : (cur_v[c] > thr));

    always_ff @(posedge clk) begin
      if (!rst_n)      prv_v[c] <= '0;
      else if (in_win) prv_v[c] <= cur_v[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       prev_ok <= 1'b0;
    else if (in_win)  prev_ok <= 1'b1;
    else if (hs_rise) prev_ok <= 1'b0;
  end

  always_comb begin
    edge_term = '0;
    sum_term  = '0;
    smp_min   = '1;
    smp_max   = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      edge_term = edge_term + TW'(e_c[c]);
      sum_term  = sum_term + TW'(s_c[c]);
      if (mn_c[c] < smp_min) smp_min = mn_c[c];
      if (mx_c[c] > smp_max) smp_max = mx_c[c];
    end
  end

  assign cnt_term = 2'($countones(hit_c));
  assign pos_pass = |pass_c;
endmodule

// File: rtl/vstat_accum.sv
module vstat_accum
  import vstat_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int COORD_W = 12,
  parameter int ACC_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               frame_end,
  input  logic               running,
  input  alg_e               alg,
  input  logic               in_win,
  input  logic [PIX_W+1:0]   edge_term,
  input  logic [PIX_W+1:0]   sum_term,
  input  logic [1:0]         cnt_term,
  input  logic [PIX_W-1:0]   smp_min,
  input  logic [PIX_W-1:0]   smp_max,
  input  logic               pos_pass,
  input  logic [COORD_W-1:0] cur_x,
  input  logic [COORD_W-1:0] cur_y,
  output logic [ACC_W-1:0]   res_main,
  output logic [ACC_W-1:0]   res_aux
);
  localparam int PW = COORD_W + 1;

  function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b);
    logic [ACC_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[ACC_W] ? '1 : s[ACC_W-1:0];
  endfunction

  logic advance, take, hit;
  logic [ACC_W-1:0]   edge_q, sum_q, cnt_q, edge_d, sum_d, cnt_d;
  logic [PIX_W-1:0]   mn_q, mx_q, mn_d, mx_d;
  logic [COORD_W-1:0] hs0_q, vs0_q, hs0_d, vs0_d;
  logic [PW-1:0]      he1_q, ve1_q, he1_d, ve1_d;
  logic [PW-1:0]      x_nx, y_nx;
  logic [ACC_W-1:0]   main_d, aux_d;
  alg_e               res_alg;

  assign advance = frame_start | (running & ~frame_end);
  assign take    = in_win & advance;
  assign hit     = take & pos_pass;
  assign x_nx    = {1'b0, cur_x} + 1'b1;
  assign y_nx    = {1'b0, cur_y} + 1'b1;

  always_comb begin
    logic [ACC_W-1:0]   e_b, s_b, c_b;
    logic [PIX_W-1:0]   mn_b, mx_b;
    logic [COORD_W-1:0] hs_b, vs_b;
    logic [PW-1:0]      he_b, ve_b;
    e_b  = frame_start ? '0 : edge_q;
    s_b  = frame_start ? '0 : sum_q;
    c_b  = frame_start ? '0 : cnt_q;
    mn_b = frame_start ? '1 : mn_q;
    mx_b = frame_start ? '0 : mx_q;
    hs_b = frame_start ? '1 : hs0_q;
    vs_b = frame_start ? '1 : vs0_q;
    he_b = frame_start ? '0 : he1_q;
    ve_b = frame_start ? '0 : ve1_q;

    edge_d = take ? sat_add(e_b, ACC_W'(edge_term)) : e_b;
    sum_d  = take ? sat_add(s_b, ACC_W'(sum_term))  : s_b;
    cnt_d  = take ? sat_add(c_b, ACC_W'(cnt_term))  : c_b;
    mn_d   = (take && smp_min < mn_b) ? smp_min : mn_b;
    mx_d   = (take && smp_max > mx_b) ? smp_max : mx_b;
    hs0_d  = (hit && cur_x < hs_b) ? cur_x : hs_b;
    vs0_d  = (hit && cur_y < vs_b) ? cur_y : vs_b;
    he1_d  = (hit && x_nx > he_b) ? x_nx : he_b;
    ve1_d  = (hit && y_nx > ve_b) ? y_nx : ve_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q <= '0;
      sum_q  <= '0;
      cnt_q  <= '0;
      mn_q   <= '1;
      mx_q   <= '0;
      hs0_q  <= '1;
      vs0_q  <= '1;
      he1_q  <= '0;
      ve1_q  <= '0;
    end else if (advance) begin
      edge_q <= edge_d;
      sum_q  <= sum_d;
      cnt_q  <= cnt_d;
      mn_q   <= mn_d;
      mx_q   <= mx_d;
      hs0_q  <= hs0_d;
      vs0_q  <= vs0_d;
      he1_q  <= he1_d;
      ve1_q  <= ve1_d;
    end
  end

  always_comb begin
    main_d = '0;
    aux_d  = '0;
    case (alg)
      ALG_EDGE:   main_d = edge_q;
      ALG_SUM:    main_d = sum_q;
      ALG_MINMAX: begin main_d = ACC_W'(mn_q);  aux_d = ACC_W'(mx_q);  end
      ALG_COUNT:  main_d = cnt_q;
      ALG_HPOS:   begin main_d = ACC_W'(hs0_q); aux_d = ACC_W'(he1_q); end
      ALG_VPOS:   begin main_d = ACC_W'(vs0_q); aux_d = ACC_W'(ve1_q); end
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_main <= '0;
      res_aux  <= '0;
      res_alg  <= ALG_EDGE;
    end else if (frame_end) begin
      res_main <= main_d;
      res_aux  <= aux_d;
      res_alg  <= alg;
    end
  end

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> ($stable(res_main) && $stable(res_aux))); // R3
  AST_MINMAX_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_alg == ALG_MINMAX) |-> ((res_main >> PIX_W) == '0 && (res_aux >> PIX_W) == '0)); // R12
  AST_HPOS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (res_alg == ALG_HPOS && res_aux != '0) |-> (res_main < res_aux)); // R10
endmodule

// File: rtl/vstat_top.sv
module vstat_top
  import vstat_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int COORD_W = 12,
  parameter int ACC_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIX_W-1:0]   pix_r,
  input  logic [PIX_W-1:0]   pix_g,
  input  logic [PIX_W-1:0]   pix_b,
  input  logic               pix_vld,
  input  logic               hsync,
  input  logic               vsync,
  input  logic               req_start,
  input  logic [2:0]         sel_alg,
  input  logic [1:0]         sel_chan,
  input  logic [PIX_W-1:0]   thr_level,
  input  logic               cnt_below,
  input  logic               pos_diff,
  input  logic [COORD_W-1:0] win_x0,
  input  logic [COORD_W-1:0] win_y0,
  input  logic [COORD_W-1:0] win_x1,
  input  logic [COORD_W-1:0] win_y1,
  output logic               busy,
  output logic [ACC_W-1:0]   res_main,
  output logic [ACC_W-1:0]   res_aux
);
  logic               hs_rise, vs_rise, running, frame_start, frame_end;
  logic [COORD_W-1:0] cur_x, cur_y, x0_q, y0_q, x1_q, y1_q;
  alg_e               alg_q;
  logic [1:0]         chan_q;
  logic [PIX_W-1:0]   thr_q, smp_min, smp_max;
  logic               below_q, diff_q, in_win, pos_pass;
  logic [PIX_W+1:0]   edge_term, sum_term;
  logic [1:0]         cnt_term;

  vstat_coord #(.COORD_W(COORD_W)) u_coord (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .hs_rise(hs_rise), .vs_rise(vs_rise), .cur_x(cur_x), .cur_y(cur_y));

  vstat_ctrl #(.PIX_W(PIX_W), .COORD_W(COORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .vs_rise(vs_rise),
    .in_alg(sel_alg), .in_chan(sel_chan), .in_thr(thr_level),
    .in_below(cnt_below), .in_diff(pos_diff),
    .in_x0(win_x0), .in_y0(win_y0), .in_x1(win_x1), .in_y1(win_y1),
    .busy(busy), .running(running), .frame_start(frame_start), .frame_end(frame_end),
    .alg_q(alg_q), .chan_q(chan_q), .thr_q(thr_q), .below_q(below_q), .diff_q(diff_q),
    .x0_q(x0_q), .y0_q(y0_q), .x1_q(x1_q), .y1_q(y1_q));

  vstat_sample #(.PIX_W(PIX_W), .COORD_W(COORD_W)) u_sample (
    .clk(clk), .rst_n(rst_n), .hs_rise(hs_rise),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .pix_vld(pix_vld),
    .cur_x(cur_x), .cur_y(cur_y), .x0(x0_q), .y0(y0_q), .x1(x1_q), .y1(y1_q),
    .chan(chan_q), .thr(thr_q), .below(below_q), .diff_mode(diff_q),
    .in_win(in_win), .edge_term(edge_term), .sum_term(sum_term), .cnt_term(cnt_term),
    .smp_min(smp_min), .smp_max(smp_max), .pos_pass(pos_pass));

  vstat_accum #(.PIX_W(PIX_W), .COORD_W(COORD_W), .ACC_W(ACC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .running(running), .alg(alg_q), .in_win(in_win),
    .edge_term(edge_term), .sum_term(sum_term), .cnt_term(cnt_term),
    .smp_min(smp_min), .smp_max(smp_max), .pos_pass(pos_pass),
    .cur_x(cur_x), .cur_y(cur_y), .res_main(res_main), .res_aux(res_aux));
endmodule

// File: tb/sim_vstat_top.sv
module sim_vstat_top;
  localparam int CLK_P = 10;
  localparam int PW = 8;
  localparam int CW = 12;
  localparam int AW = 16;
  localparam int HT = 24;
  localparam int VT = 10;
  localparam longint SATV = (longint'(1) << AW) - 1;
  localparam int CMX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic [PW-1:0] pix_r = 0, pix_g = 0, pix_b = 0, thr_level = 0;
  logic pix_vld = 0, hsync = 0, vsync = 0, req_start = 0, cnt_below = 0, pos_diff = 0;
  logic [2:0] sel_alg = 0;
  logic [1:0] sel_chan = 0;
  logic [CW-1:0] win_x0 = 0, win_y0 = 0, win_x1 = 0, win_y1 = 0;
  logic busy;
  logic [AW-1:0] res_main, res_aux;

  int total = 0, bad = 0, done = 0;
  int pc = 0, lc = 0, dmode = 0;

  always #(CLK_P/2) clk = ~clk;

  vstat_top #(.PIX_W(PW), .COORD_W(CW), .ACC_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .pix_vld(pix_vld), .hsync(hsync), .vsync(vsync), .req_start(req_start),
    .sel_alg(sel_alg), .sel_chan(sel_chan), .thr_level(thr_level),
    .cnt_below(cnt_below), .pos_diff(pos_diff), .win_x0(win_x0), .win_y0(win_y0),
    .win_x1(win_x1), .win_y1(win_y1), .busy(busy), .res_main(res_main), .res_aux(res_aux));

  // ---------------- behavioural reference ----------------
  int m_busy, m_run, m_ralg, phs, pvs, px, py, pok;
  int pr[3];
  int c_alg, c_ch, c_thr, c_below, c_diff, c_x0, c_y0, c_x1, c_y1;
  longint a_edge, a_sum, a_cnt, m_main, m_aux;
  int a_mn, a_mx, a_hs, a_he, a_vs, a_ve;

  always @(posedge clk) begin : model
    int hr, vr, ex, ey, win, pe, fs, fe, take, b0, pass, d;
    int v[3];
    if (!rst_n) begin
      m_busy = 0; m_run = 0; m_ralg = 0; m_main = 0; m_aux = 0;
      phs = 0; pvs = 0; px = CMX; py = CMX; pok = 0;
      pr[0] = 0; pr[1] = 0; pr[2] = 0;
      c_alg = 0; c_ch = 0; c_thr = 0; c_below = 0; c_diff = 0;
      c_x0 = 0; c_y0 = 0; c_x1 = 0; c_y1 = 0;
    end else begin
      v[0] = int'(pix_r); v[1] = int'(pix_g); v[2] = int'(pix_b);
      hr = (hsync && !phs) ? 1 : 0;
      vr = (vsync && !pvs) ? 1 : 0;
      ex = hr ? 0 : (px >= CMX ? CMX : px + 1);
      ey = vr ? 0 : (hr ? (py >= CMX ? CMX : py + 1) : py);
      win = (pix_vld && ex >= c_x0 && ex <= c_x1 && ey >= c_y0 && ey <= c_y1) ? 1 : 0;
      pe = (pok && !hr) ? 1 : 0;
      b0 = m_busy;
      fs = (m_busy && !m_run && vr) ? 1 : 0;
      fe = (m_run && vr) ? 1 : 0;
      take = (win && (fs || (m_run && !vr))) ? 1 : 0;
      if (fe) begin
        m_ralg = c_alg;
        case (c_alg)
          0: begin m_main = a_edge; m_aux = 0; end
          1: begin m_main = a_sum;  m_aux = 0; end
          2: begin m_main = a_mn;   m_aux = a_mx; end
          3: begin m_main = a_cnt;  m_aux = 0; end
          4: begin m_main = a_hs;   m_aux = a_he; end
          5: begin m_main = a_vs;   m_aux = a_ve; end
          default: begin m_main = 0; m_aux = 0; end
        endcase
        m_busy = 0; m_run = 0;
      end
      if (fs) begin
        a_edge = 0; a_sum = 0; a_cnt = 0; a_mn = 255; a_mx = 0;
        a_hs = CMX; a_he = 0; a_vs = CMX; a_ve = 0;
        m_run = 1;
      end
      if (take) begin
        pass = 0;
        for (int c = 0; c < 3; c++) begin
          if (c_ch == 3 || c_ch == c) begin
            d = (v[c] > pr[c]) ? v[c] - pr[c] : pr[c] - v[c];
            if (pe && d > c_thr) a_edge += d - c_thr;
            a_sum += v[c];
            if (c_below ? (v[c] < c_thr) : (v[c] > c_thr)) a_cnt += 1;
            if (v[c] < a_mn) a_mn = v[c];
            if (v[c] > a_mx) a_mx = v[c];
            if (c_diff ? (pe && d > c_thr) : (v[c] > c_thr)) pass = 1;
          end
        end
        if (a_edge > SATV) a_edge = SATV;
        if (a_sum > SATV) a_sum = SATV;
        if (a_cnt > SATV) a_cnt = SATV;
        if (pass) begin
          if (ex < a_hs) a_hs = ex;
          if (ex + 1 > a_he) a_he = ex + 1;
          if (ey < a_vs) a_vs = ey;
          if (ey + 1 > a_ve) a_ve = ey + 1;
        end
      end
      if (win) begin
        pr[0] = v[0]; pr[1] = v[1]; pr[2] = v[2]; pok = 1;
      end else if (hr) pok = 0;
      if (req_start && !b0) begin
        m_busy = 1;
        c_alg = int'(sel_alg); c_ch = int'(sel_chan); c_thr = int'(thr_level);
        c_below = int'(cnt_below); c_diff = int'(pos_diff);
        c_x0 = int'(win_x0); c_y0 = int'(win_y0); c_x1 = int'(win_x1); c_y1 = int'(win_y1);
      end
      phs = hsync; pvs = vsync; px = ex; py = ey;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int alg);
    case (alg)
      0: return "R6";
      1: return "R7";
      2: return "R8";
      3: return "R9";
      4: return "R10";
      5: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic int pick(input int mode);
    case (mode)
      1: return (($urandom % 8) == 0) ? int'($urandom_range(100, 255)) : int'($urandom_range(0, 20));
      2: return 255;
      default: return int'($urandom_range(0, 255));
    endcase
  endfunction

  // one clock: compare at the falling edge, then drive the next sample
  task automatic tick();
    @(negedge clk);
    chk("R3", "busy", longint'(busy), longint'(m_busy));
    chk(tag_of(m_ralg), "res_main", longint'(res_main), m_main);
    chk(tag_of(m_ralg), "res_aux", longint'(res_aux), m_aux);
    hsync   = (pc < 2);
    vsync   = (lc == 0);
    pix_vld = (lc >= 1 && pc >= 3 && pc <= 21 && ($urandom % 5) != 0);
    pix_r   = PW'(pick(dmode));
    pix_g   = PW'(pick(dmode));
    pix_b   = PW'(pick(dmode));
    pc++;
    if (pc == HT) begin pc = 0; lc = (lc + 1) % VT; end
  endtask

  task automatic run_meas(input int alg, input int ch, input int thr, input int blw,
                          input int dif, input int x0, input int y0, input int x1,
                          input int y1, input int mode, input int churn, input string tag);
    int guard;
    dmode = mode;
    sel_alg = 3'(alg); sel_chan = 2'(ch); thr_level = PW'(thr);
    cnt_below = blw[0]; pos_diff = dif[0];
    win_x0 = CW'(x0); win_y0 = CW'(y0); win_x1 = CW'(x1); win_y1 = CW'(y1);
    req_start = 1;
    tick();
    req_start = 0;
    guard = 0;
    while (m_busy && guard < 1000) begin
      if (churn) begin
        sel_alg = 3'($urandom); sel_chan = 2'($urandom); thr_level = PW'($urandom);
        cnt_below = 1'($urandom); pos_diff = 1'($urandom);
        win_x0 = CW'($urandom_range(0, 8)); win_x1 = CW'($urandom_range(9, 30));
        req_start = 1'($urandom);
      end
      tick();
      guard++;
    end
    req_start = 0;
    tick();
    chk(tag, "busy cleared", longint'(busy), 0);
    chk(tag, "final main", longint'(res_main), m_main);
    chk(tag, "final aux", longint'(res_aux), m_aux);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "busy after reset", longint'(busy), 0);
    chk("R1", "res_main after reset", longint'(res_main), 0);
    chk("R1", "res_aux after reset", longint'(res_aux), 0);
    repeat (30) tick();
    run_meas(0, 3, 10, 0, 0, 0, 0, CMX, CMX, 0, 0, "R6");
    run_meas(0, 1, 0, 0, 0, 5, 2, 15, 7, 0, 0, "R6");
    run_meas(1, 0, 0, 0, 0, 0, 0, CMX, CMX, 0, 0, "R7");
    run_meas(1, 3, 0, 0, 0, 0, 0, CMX, CMX, 2, 0, "R7");     // saturation
    run_meas(2, 2, 0, 0, 0, 4, 1, 12, 5, 0, 0, "R8");
    run_meas(2, 3, 0, 0, 0, 30, 0, 40, CMX, 0, 0, "R8");     // empty region
    run_meas(3, 3, 128, 0, 0, 0, 0, CMX, CMX, 0, 0, "R9");
    run_meas(3, 1, 128, 1, 0, 0, 0, CMX, CMX, 0, 0, "R9");
    run_meas(4, 3, 90, 0, 0, 0, 0, CMX, CMX, 1, 0, "R10");
    run_meas(4, 0, 60, 0, 1, 0, 0, CMX, CMX, 1, 0, "R10");
    run_meas(4, 3, 255, 0, 0, 0, 0, CMX, CMX, 0, 0, "R10"); // nothing passes
    run_meas(5, 3, 90, 0, 0, 0, 2, CMX, 8, 1, 0, "R11");
    run_meas(5, 2, 50, 0, 1, 0, 0, CMX, CMX, 1, 0, "R11");
    run_meas(6, 3, 0, 0, 0, 0, 0, CMX, CMX, 0, 0, "R12");
    run_meas(2, 3, 0, 0, 0, 0, 0, CMX, CMX, 0, 0, "R12");
    run_meas(1, 3, 0, 0, 0, 0, 0, CMX, CMX, 0, 1, "R2");    // config churn
    run_meas(3, 0, 100, 0, 0, 6, 3, 10, 4, 0, 0, "R4");
    run_meas(1, 2, 0, 0, 0, 0, 0, CMX, CMX, 0, 0, "R5");
    run_meas(1, 1, 0, 0, 0, 0, 0, CMX, CMX, 0, 0, "R5");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule